// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether one memory access may go ahead, given the attribute bits of the page it targets. Each request carries the access kind (load or store), the privilege level of the requester (user or kernel), a flag saying whether translation produced a usable entry, and the page attributes: present, may-read, may-write, kernel-only and modified.

One cycle after a request is taken, the block returns three things. The first is a grant. The second is a 3-bit fault cause. The third is a request to set the modified bit, raised when a store is granted to a page that is still clean. Read and write permission are independent, so a page can be read-only or write-only.

Requests and responses each use a valid/ready handshake. A request is taken whenever the response register is empty or is being drained in the same cycle. Fault handling, table walking and operating-system policy live elsewhere.

Top module: `page_perm_check`

## Requirements
- R1: A request whose present bit or translation-usable flag is 0 is never granted and reports cause 3'b001.
- R2: A usable request to a kernel-only page from user mode (priv_kernel = 0) is denied with cause 3'b100. From kernel mode the kernel-only bit blocks nothing.
- R3: A usable, privilege-permitted load to a page whose may-read bit is 0 is denied with cause 3'b010.
- R4: A usable, privilege-permitted store to a page whose may-write bit is 0 is denied with cause 3'b011. A store to a write-only page (may-write 1, may-read 0) is granted.
- R5: A granted response reports cause 3'b000, and a response with cause 3'b000 is granted.
- R6: rsp_set_dirty is 1 exactly when the response grants a store and the page's modified bit was 0. A denied access never raises it.
- R7: The response becomes valid in the cycle after a request is accepted. req_ready is 1 whenever rsp_valid is 0 or rsp_ready is 1.
- R8: While rsp_valid is 1 and rsp_ready is 0, the response and all its fields hold unchanged.
- R9: Reset (rst_n low) clears rsp_valid.
- R10: Causes are ranked. Invalid (3'b001) outranks privilege (3'b100), and privilege outranks read or write denial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_store | input | 1 | 1 = store, 0 = load |
| priv_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| xlat_ok | input | 1 | Translation produced a usable entry |
| pg_present | input | 1 | Entry valid bit |
| pg_read | input | 1 | Page may be read |
| pg_write | input | 1 | Page may be written |
| pg_kern_only | input | 1 | Page restricted to kernel mode |
| pg_dirty | input | 1 | Page already modified |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_grant | output | 1 | Access allowed |
| rsp_cause | output | 3 | Fault cause (000 none, 001 invalid, 010 read, 011 write, 100 privilege) |
| rsp_set_dirty | output | 1 | Request to set the page's modified bit |

## Verification
The embedded properties check on every cycle that an accepted request gives a valid response one cycle later. They also check that a stalled response holds, that invalid or user-to-kernel requests are never granted, and that grant, zero cause and the dirty request stay consistent. Whether each cause is the right one for a given attribute mix, how the causes are ranked, and what the reset does are shown only by the bench's scenarios. In those scenarios a behavioural model follows directed cases, random traffic and back-pressure.

// File: rtl/page_perm_pkg.sv
package page_perm_pkg;
  localparam int CAUSE_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE  = 3'b000,
    CAUSE_INVAL = 3'b001,
    CAUSE_RDENY = 3'b010,
    CAUSE_WDENY = 3'b011,
    CAUSE_PRIV  = 3'b100
  } cause_e;

  typedef struct packed {
    logic present;
    logic rd;
    logic wr;
    logic kern_only;
    logic dirty;
  } pg_attr_t;

  typedef struct packed {
    logic   store;
    logic   kernel;
    logic   xlat_ok;
    pg_attr_t attr;
  } chk_req_t;

  typedef struct packed {
    logic   grant;
    cause_e cause;
    logic   set_dirty;
  } chk_rsp_t;
endpackage

// File: rtl/page_perm_eval.sv
module page_perm_eval
  import page_perm_pkg::*;
(
  input  chk_req_t req,
  output chk_rsp_t rsp
);
  logic usable;
  logic priv_fail;
  logic perm_fail;

  always_comb begin
    usable    = req.xlat_ok & req.attr.present;
    priv_fail = req.attr.kern_only & ~req.kernel;
    perm_fail = req.store ? ~req.attr.wr : ~req.attr.rd;

    rsp.grant = usable & ~priv_fail & ~perm_fail;
    if (!usable)         rsp.cause = CAUSE_INVAL;
    else if (priv_fail)  rsp.cause = CAUSE_PRIV;
    else if (perm_fail)  rsp.cause = req.store ? CAUSE_WDENY : CAUSE_RDENY;
    else                 rsp.cause = CAUSE_NONE;
    rsp.set_dirty = rsp.grant & req.store & ~req.attr.dirty;
  end
endmodule

// File: rtl/page_perm_rsp_stage.sv
module page_perm_rsp_stage
  import page_perm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  chk_rsp_t in_data,
  output logic     out_valid,
  input  logic     out_ready,
  output chk_rsp_t out_data
);
  logic     vld_q, vld_d;
  chk_rsp_t dat_q, dat_d;
  logic     load_en;

  assign in_ready = ~vld_q | out_ready;
  assign load_en  = in_valid & in_ready;

  always_comb begin
    vld_d = vld_q;
    dat_d = dat_q;
    if (load_en) begin
      vld_d = 1'b1;
      dat_d = in_data;
    end else if (out_ready) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) dat_q <= dat_d;
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
  import page_perm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_store,
  input  logic               priv_kernel,
  input  logic               xlat_ok,
  input  logic               pg_present,
  input  logic               pg_read,
  input  logic               pg_write,
  input  logic               pg_kern_only,
  input  logic               pg_dirty,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_grant,
  output logic [CAUSE_W-1:0] rsp_cause,
  output logic               rsp_set_dirty
);
  chk_req_t req;
  chk_rsp_t eval_rsp;
  chk_rsp_t held_rsp;

  always_comb begin
    req.store          = req_store;
    req.kernel         = priv_kernel;
    req.xlat_ok        = xlat_ok;
    req.attr.present   = pg_present;
    req.attr.rd        = pg_read;
    req.attr.wr        = pg_write;
    req.attr.kern_only = pg_kern_only;
    req.attr.dirty     = pg_dirty;
  end

  page_perm_eval u_eval (
    .req (req),
    .rsp (eval_rsp)
  );

  page_perm_rsp_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (eval_rsp),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (held_rsp)
  );

  assign rsp_grant     = held_rsp.grant;
  assign rsp_cause     = held_rsp.cause;
  assign rsp_set_dirty = held_rsp.set_dirty;

  p_invalid_denied_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (!pg_present || !xlat_ok))
      |=> (!rsp_grant && rsp_cause == 3'b001));

  p_user_kernel_denied_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !priv_kernel && pg_kern_only) |=> !rsp_grant);

  p_grant_zero_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_grant == (rsp_cause == 3'b000)));

  p_dirty_needs_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_set_dirty) |-> rsp_grant);
endmodule

// File: tb/page_perm_check_test.sv
module page_perm_check_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_store = 1'b0, priv_kernel = 1'b0, xlat_ok = 1'b0;
  logic pg_present = 1'b0, pg_read = 1'b0, pg_write = 1'b0, pg_kern_only = 1'b0, pg_dirty = 1'b0;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid, rsp_grant, rsp_set_dirty;
  logic [2:0] rsp_cause;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic       m_valid;
  logic       m_grant;
  logic [2:0] m_cause;
  logic       m_dirty;

  always #5 clk = ~clk;

  page_perm_check uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .priv_kernel(priv_kernel), .xlat_ok(xlat_ok),
    .pg_present(pg_present), .pg_read(pg_read), .pg_write(pg_write),
    .pg_kern_only(pg_kern_only), .pg_dirty(pg_dirty), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_grant(rsp_grant), .rsp_cause(rsp_cause),
    .rsp_set_dirty(rsp_set_dirty)
  );

  function automatic logic [2:0] ref_cause(input logic st, kern, ok, p, r, w, k);
    if (!ok || !p) return 3'b001;
    if (k && !kern) return 3'b100;
    if (st && !w) return 3'b011;
    if (!st && !r) return 3'b010;
    return 3'b000;
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'b001: return "R1/R10";
      3'b100: return "R2/R10";
      3'b010: return "R3";
      3'b011: return "R4";
      default: return "R5";
    endcase
  endfunction

  // behavioural reference, updated on every edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_valid <= 1'b0;
    else if (req_valid && (!m_valid || rsp_ready)) begin
      m_valid <= 1'b1;
      m_cause <= ref_cause(req_store, priv_kernel, xlat_ok, pg_present, pg_read, pg_write, pg_kern_only);
      m_grant <= (ref_cause(req_store, priv_kernel, xlat_ok, pg_present, pg_read, pg_write, pg_kern_only) == 3'b000);
      m_dirty <= (ref_cause(req_store, priv_kernel, xlat_ok, pg_present, pg_read, pg_write, pg_kern_only) == 3'b000)
                 && req_store && !pg_dirty;
    end else if (rsp_ready) m_valid <= 1'b0;
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    checks++;
    if (rsp_valid !== m_valid) begin
      fails++;
      $display("FAIL R7/R9 rsp_valid actual=%b expected=%b", rsp_valid, m_valid);
    end
    checks++;
    if (req_ready !== (!m_valid || rsp_ready)) begin
      fails++;
      $display("FAIL R7/R8 req_ready actual=%b expected=%b", req_ready, !m_valid || rsp_ready);
    end
    if (m_valid) begin
      checks++;
      if (rsp_cause !== m_cause || rsp_grant !== m_grant) begin
        fails++;
        $display("FAIL %s grant/cause actual=%b/%b expected=%b/%b",
                 tag_of(m_cause), rsp_grant, rsp_cause, m_grant, m_cause);
      end
      checks++;
      if (rsp_set_dirty !== m_dirty) begin
        fails++;
        $display("FAIL R6 set_dirty actual=%b expected=%b", rsp_set_dirty, m_dirty);
      end
    end
  end

  task automatic drive(input logic v, st, kern, ok, p, r, w, k, d, rr);
    @(posedge clk); #2;
    req_valid = v; req_store = st; priv_kernel = kern; xlat_ok = ok;
    pg_present = p; pg_read = r; pg_write = w; pg_kern_only = k; pg_dirty = d;
    rsp_ready = rr;
  endtask

  task automatic one(input logic st, kern, ok, p, r, w, k, d);
    drive(1'b1, st, kern, ok, p, r, w, k, d, 1'b1);
    drive(1'b0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R9: reset state compared at the first negedges
    // R1: invalid entry, and translation flag clear
    one(0, 1, 1, 0, 1, 1, 0, 0);
    one(1, 1, 0, 1, 1, 1, 0, 0);
    // R10: invalid outranks privilege, privilege outranks read denial
    one(0, 0, 1, 0, 0, 0, 1, 0);
    one(0, 0, 1, 1, 0, 0, 1, 0);
    // R2: kernel-only page from user and from kernel
    one(0, 0, 1, 1, 1, 1, 1, 0);
    one(0, 1, 1, 1, 1, 1, 1, 0);
    // R3: load to write-only page; R4: store to read-only page
    one(0, 1, 1, 1, 0, 1, 0, 0);
    one(1, 1, 1, 1, 1, 0, 0, 0);
    // R4/R6: store to write-only clean page granted and marks dirty
    one(1, 0, 1, 1, 0, 1, 0, 0);
    // R6/R5: store to already-dirty page, load granted
    one(1, 0, 1, 1, 1, 1, 0, 1);
    one(0, 0, 1, 1, 1, 0, 0, 0);
    // R6: denied store to clean page raises no dirty request
    one(1, 0, 1, 1, 1, 0, 0, 0);
    // R8: stalled response held while new requests arrive
    drive(1, 1, 0, 1, 1, 1, 1, 0, 0, 1'b0);
    drive(1, 0, 0, 1, 0, 0, 0, 0, 0, 1'b0);
    drive(1, 0, 0, 1, 0, 0, 0, 0, 0, 1'b0);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b1);
    // random traffic with back-pressure (R1..R8, R10)
    for (int i = 0; i < 3000; i++)
      drive($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
            ($urandom_range(0,7) != 0), ($urandom_range(0,7) != 0),
            $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
            $urandom_range(0,1), ($urandom_range(0,3) != 0));
    // R9: reset in the middle of a stalled response
    drive(1, 0, 1, 1, 1, 1, 0, 0, 0, 1'b0);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
    rst_n = 1'b0;
    @(posedge clk); #2 rst_n = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b1);
    repeat (2) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule